// File: doc/BRIEF.md
# PCI Configuration Window Translator

This block sits between a CPU-side memory-mapped request port and a simple PCI configuration master. It claims CPU accesses that fall inside a 4 MiB window starting at 0x8080_0000. For each such access it builds a 15-bit configuration address. The low eleven bits of the CPU address pass through as the register offset. A 4-bit device number is found by a lowest-first search of the one-hot select bits 11 to 21. The block also reverses the byte order of 16-bit and 32-bit data in both directions, because the CPU side is big-endian and the configuration port is little-endian.

Only one configuration transaction can be in flight. While one is pending, the CPU port holds ready low, and the response pulse returns the read data once the configuration port acknowledges. An access that misses the window starts no configuration transaction. It is completed locally with a zero response on the next cycle, so the CPU never stalls on it.

Top module: `cfg_window_xlate`

## Requirements
- R1: A request with address bits [31:22] equal to 0x202 (window 0x8080_0000 to 0x80BF_FFFF) starts a configuration request. Any other address starts none and gets `cpu_rsp_valid` high on the next cycle with `cpu_rsp_rdata` = 0.
- R2: `cfg_req_addr[10:0]` equals CPU address bits [10:0].
- R3: `cfg_req_addr[14:11]` holds the index i (0..10) of the lowest set bit among CPU address bits 11+i, so bit 11 gives 0 and bit 21 gives 10. Lower set bits win over higher ones.
- R4: When none of CPU address bits 11..21 is set, `cfg_req_addr[14:11]` is 11.
- R5: `cfg_req_size` carries the CPU size code unchanged. The codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R6: With size code 0, write data goes to `cfg_req_wdata` unchanged, and `cfg_rdata` comes back on `cpu_rsp_rdata` unchanged.
- R7: With size code 1, a 32-bit value d becomes {16'h0, d[7:0], d[15:8]}. This applies both to write data going out and to read data coming back.
- R8: With size code 2, a value becomes {d[7:0], d[15:8], d[23:16], d[31:24]}. This applies both to write data going out and to read data coming back.
- R9: From the cycle after an in-window request is accepted until the cycle after `cfg_ack`, `cfg_req_valid` is high, `cpu_req_ready` is low and the request fields are stable.
- R10: The cycle after `cfg_ack` is seen with `cfg_req_valid` high, `cpu_rsp_valid` is high for one cycle, `cfg_req_valid` is low and `cpu_req_ready` is high.
- R11: During and right after reset, `cpu_req_ready` is high, `cfg_req_valid` is low and `cpu_rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_size | input | 2 | Size code (0/1/2 = 1/2/4 bytes) |
| cpu_req_addr | input | 32 | CPU byte address |
| cpu_req_wdata | input | 32 | CPU write data, big-endian order |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read data, big-endian order |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_write | output | 1 | Configuration write flag |
| cfg_req_size | output | 2 | Configuration size code |
| cfg_req_addr | output | 15 | Device number [14:11], register offset [10:0] |
| cfg_req_wdata | output | 32 | Write data, little-endian order |
| cfg_ack | input | 1 | Configuration port completes the request |
| cfg_rdata | input | 32 | Read data from the configuration port, valid with `cfg_ack` |

## Verification
Two events can fall in the same clock edge here. One is the completion of a configuration transaction, which raises the response pulse and frees the port. The other is the acceptance of a CPU request that was held waiting on ready. The bench provokes this by keeping a second in-window request asserted through the whole busy period of the first. It then acknowledges the first one and checks the sequence. The response data of the first request must use the first request's size for its swap. The second request must then be forwarded one edge later with its own device number, offset and swapped write data. A behavioural reference model compares every output on every clock, so neither transaction can corrupt the other without being reported.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Reorders byte lanes between CPU and configuration order.
  function automatic logic [DATA_W-1:0] lane_swap(input logic [1:0] sz,
                                                  input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    case (sz)
      SZ_HALF: r = {16'h0000, d[7:0], d[15:8]};
      SZ_WORD: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfw_addr_map.sv
module cfw_addr_map #(
  parameter int OFS_W = 11,
  parameter int SEL_N = 11,
  parameter int DEV_W = 4,
  localparam int IN_W  = OFS_W + SEL_N,
  localparam int OUT_W = OFS_W + DEV_W
) (
  input  logic [IN_W-1:0]  win_addr,
  output logic [OUT_W-1:0] cfg_addr
);
  logic [DEV_W-1:0] dev;

  // Lowest set select bit wins; none set gives the scan count.
  always_comb begin
    dev = DEV_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--) begin
      if (win_addr[OFS_W + i]) dev = DEV_W'(i);
    end
  end

  assign cfg_addr = {dev, win_addr[OFS_W-1:0]};
endmodule

// File: rtl/cfw_lane_swap.sv
module cfw_lane_swap
  import cfw_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  assign dout = lane_swap(size, din);
endmodule

// File: rtl/cfw_ctrl.sv
module cfw_ctrl
  import cfw_pkg::*;
#(
  parameter int CFG_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_hit,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [CFG_AW-1:0] req_cfg_addr,
  input  logic [DATA_W-1:0] req_wdata_sw,
  output logic              req_ready,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [1:0]        cfg_size,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_ack,
  input  logic [DATA_W-1:0] cfg_rdata_sw,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
  st_e st;

  assign req_ready = (st == ST_IDLE);
  assign cfg_valid = (st == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cfg_write <= 1'b0;
      cfg_size  <= SZ_BYTE;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_hit) begin
              st        <= ST_BUSY;
              cfg_write <= req_write;
              cfg_size  <= req_size;
              cfg_addr  <= req_cfg_addr;
              cfg_wdata <= req_wdata_sw;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
          end
        end
        ST_BUSY: begin
          if (cfg_ack) begin
            st        <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= cfg_rdata_sw;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
  import cfw_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_LOG2 = 22,
  parameter int          OFS_W    = 11,
  parameter int          SEL_N    = 11,
  parameter int          DEV_W    = 4,
  localparam int         CFG_AW   = OFS_W + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [1:0]        cpu_req_size,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cfg_req_valid,
  output logic              cfg_req_write,
  output logic [1:0]        cfg_req_size,
  output logic [CFG_AW-1:0] cfg_req_addr,
  output logic [DATA_W-1:0] cfg_req_wdata,
  input  logic              cfg_ack,
  input  logic [DATA_W-1:0] cfg_rdata
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  // Named internal events, also observed by the bound checker.
  logic              acc_hit;
  logic              acc_fire;
  logic [CFG_AW-1:0] acc_cfg_addr;
  logic [DATA_W-1:0] wdata_sw;
  logic [DATA_W-1:0] rdata_sw;

  assign acc_hit  = (cpu_req_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign acc_fire = cpu_req_valid && cpu_req_ready;

  cfw_addr_map #(.OFS_W(OFS_W), .SEL_N(SEL_N), .DEV_W(DEV_W)) u_addr_map (
    .win_addr (cpu_req_addr[OFS_W+SEL_N-1:0]),
    .cfg_addr (acc_cfg_addr)
  );

  cfw_lane_swap u_wr_swap (
    .size (cpu_req_size),
    .din  (cpu_req_wdata),
    .dout (wdata_sw)
  );

  cfw_lane_swap u_rd_swap (
    .size (cfg_req_size),
    .din  (cfg_rdata),
    .dout (rdata_sw)
  );

  cfw_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (cpu_req_valid),
    .req_hit      (acc_hit),
    .req_write    (cpu_req_write),
    .req_size     (cpu_req_size),
    .req_cfg_addr (acc_cfg_addr),
    .req_wdata_sw (wdata_sw),
    .req_ready    (cpu_req_ready),
    .cfg_valid    (cfg_req_valid),
    .cfg_write    (cfg_req_write),
    .cfg_size     (cfg_req_size),
    .cfg_addr     (cfg_req_addr),
    .cfg_wdata    (cfg_req_wdata),
    .cfg_ack      (cfg_ack),
    .cfg_rdata_sw (rdata_sw),
    .rsp_valid    (cpu_rsp_valid),
    .rsp_rdata    (cpu_rsp_rdata)
  );
endmodule

// File: rtl/cfw_checker.sv
module cfw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_fire,
  input logic        acc_hit,
  input logic [31:0] cpu_req_addr,
  input logic        cpu_req_ready,
  input logic        cpu_rsp_valid,
  input logic [31:0] cpu_rsp_rdata,
  input logic        cfg_req_valid,
  input logic [14:0] cfg_req_addr,
  input logic        cfg_ack
);
  assert_miss_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !acc_hit) |=> (!cfg_req_valid && cpu_rsp_valid && cpu_rsp_rdata == 32'h0));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_hit) |=> (cfg_req_valid && cfg_req_addr[10:0] == $past(cpu_req_addr[10:0])));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> !cpu_req_ready);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_ack) |=> (cfg_req_valid && $stable(cfg_req_addr)));

  assert_ack_completes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_ack) |=> (cpu_rsp_valid && !cfg_req_valid && cpu_req_ready));
endmodule

bind cfg_window_xlate cfw_checker u_cfw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_fire      (acc_fire),
  .acc_hit       (acc_hit),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_rdata (cpu_rsp_rdata),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_addr  (cfg_req_addr),
  .cfg_ack       (cfg_ack)
);

// File: tb/cfg_window_xlate_bench.sv
module cfg_window_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [1:0]  cpu_req_size = 2'd0;
  logic [31:0] cpu_req_addr = 32'h0;
  logic [31:0] cpu_req_wdata = 32'h0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        cfg_req_valid;
  logic        cfg_req_write;
  logic [1:0]  cfg_req_size;
  logic [14:0] cfg_req_addr;
  logic [31:0] cfg_req_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = 32'h0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cfg_window_xlate u_cfg_window_xlate (.*);

  // Reference helpers, written independently of the design.
  function automatic bit ref_hit(input logic [31:0] a);
    return (a >= 32'h8080_0000) && (a < 32'h80C0_0000);
  endfunction

  function automatic logic [14:0] ref_cfg_addr(input logic [31:0] a);
    int dev = 0;
    while (dev < 11 && a[11 + dev] == 1'b0) dev++;
    return {4'(dev), a[10:0]};
  endfunction

  function automatic logic [31:0] ref_swap(input logic [1:0] sz, input logic [31:0] d);
    byte unsigned b[4];
    for (int k = 0; k < 4; k++) b[k] = d[8*k +: 8];
    if (sz == 2'd1) return {16'h0, b[0], b[1]};
    if (sz == 2'd2) return {b[0], b[1], b[2], b[3]};
    return d;
  endfunction

  // Cycle model.
  bit          m_busy = 0;
  bit          m_rv = 0;
  logic [31:0] m_rd = 0;
  logic [14:0] m_addr = 0;
  logic [1:0]  m_size = 0;
  bit          m_write = 0;
  logic [31:0] m_wdata = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = 0;
      if (m_busy) begin
        if (cfg_ack) begin
          m_busy = 0; m_rv = 1; m_rd = ref_swap(m_size, cfg_rdata);
        end
      end else if (cpu_req_valid) begin
        if (ref_hit(cpu_req_addr)) begin
          m_busy = 1;
          m_addr = ref_cfg_addr(cpu_req_addr);
          m_size = cpu_req_size;
          m_write = cpu_req_write;
          m_wdata = ref_swap(cpu_req_size, cpu_req_wdata);
        end else begin
          m_rv = 1; m_rd = 0;
        end
      end
    end
  end

  function automatic string sz_tag(input logic [1:0] sz);
    if (sz == 2'd1) return "R7";
    if (sz == 2'd2) return "R8";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      // R11: reset state
      chk(cpu_req_ready === 1'b1, "R11", "ready in reset", 32'(cpu_req_ready), 1);
      chk(cfg_req_valid === 1'b0, "R11", "cfg valid in reset", 32'(cfg_req_valid), 0);
      chk(cpu_rsp_valid === 1'b0, "R11", "rsp valid in reset", 32'(cpu_rsp_valid), 0);
    end else begin
      // R9: ready low and request held while busy
      chk(cpu_req_ready === !m_busy, "R9", "cpu_req_ready", 32'(cpu_req_ready), 32'(!m_busy));
      // R1: request only for in-window accesses
      chk(cfg_req_valid === m_busy, "R1", "cfg_req_valid", 32'(cfg_req_valid), 32'(m_busy));
      if (m_busy) begin
        chk(cfg_req_addr[10:0] === m_addr[10:0], "R2", "offset",
            32'(cfg_req_addr[10:0]), 32'(m_addr[10:0]));
        chk(cfg_req_addr[14:11] === m_addr[14:11], (m_addr[14:11] == 4'd11) ? "R4" : "R3",
            "device field", 32'(cfg_req_addr[14:11]), 32'(m_addr[14:11]));
        chk(cfg_req_size === m_size, "R5", "size", 32'(cfg_req_size), 32'(m_size));
        chk(cfg_req_write === m_write, "R5", "write flag", 32'(cfg_req_write), 32'(m_write));
        chk(cfg_req_wdata === m_wdata, sz_tag(m_size), "write data", cfg_req_wdata, m_wdata);
      end
      // R10: response pulse and read data
      chk(cpu_rsp_valid === m_rv, "R10", "cpu_rsp_valid", 32'(cpu_rsp_valid), 32'(m_rv));
      if (m_rv)
        chk(cpu_rsp_rdata === m_rd, sz_tag(m_size), "read data", cpu_rsp_rdata, m_rd);
    end
  end

  task automatic drive_req(input bit w, input logic [1:0] sz,
                           input logic [31:0] a, input logic [31:0] d);
    cpu_req_valid = 1'b1;
    cpu_req_write = w;
    cpu_req_size  = sz;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input int lat, input logic [31:0] rd);
    @(negedge clk);
    drive_req(w, sz, a, d);
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (ref_hit(a)) begin
      repeat (lat) @(negedge clk);
      cfg_ack = 1'b1;
      cfg_rdata = rd;
      @(negedge clk);
      cfg_ack = 1'b0;
      cfg_rdata = 32'hDEAD_BEEF;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: bit 11 -> device 0, byte read (R6)
    access(0, 2'd0, 32'h8080_0800, 32'h0, 1, 32'h0000_00A5);
    // R3: bit 13 -> device 2, half write (R7)
    access(1, 2'd1, 32'h8080_2004, 32'h0000_1234, 0, 32'h0);
    // R3: bit 21 -> device 10, word read (R8)
    access(0, 2'd2, 32'h80A0_0010, 32'h0, 2, 32'h1122_3344);
    // R4: no select bit -> 11, word write (R8)
    access(1, 2'd2, 32'h8080_0123, 32'hA1B2_C3D4, 1, 32'h0);
    // R3: several bits set, lowest (bit 12) wins, half read (R7)
    access(0, 2'd1, 32'h80A0_57FE, 32'h0, 3, 32'hFFFF_BEEF);
    // R6: byte write keeps data
    access(1, 2'd0, 32'h8081_0003, 32'h0000_007E, 0, 32'h0);
    // R1: outside the window on both sides
    access(0, 2'd2, 32'h807F_FFFC, 32'h0, 0, 32'h0);
    access(1, 2'd2, 32'h80C0_0000, 32'h5555_AAAA, 0, 32'h0);
    access(0, 2'd0, 32'h0000_0CF8, 32'h0, 0, 32'h0);
    // R9/R10: second request held during first; completion and acceptance adjoin
    @(negedge clk);
    drive_req(0, 2'd2, 32'h8080_4010, 32'h0);
    @(negedge clk);
    drive_req(1, 2'd1, 32'h8088_0020, 32'h0000_CAFE);
    repeat (3) @(negedge clk);
    cfg_ack = 1'b1; cfg_rdata = 32'h0102_0304;
    @(negedge clk);
    cfg_ack = 1'b0;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    repeat (2) @(negedge clk);
    cfg_ack = 1'b1; cfg_rdata = 32'h0000_0000;
    @(negedge clk);
    cfg_ack = 1'b0;
    // R1: back-to-back misses
    @(negedge clk);
    drive_req(0, 2'd0, 32'h1000_0000, 32'h0);
    repeat (3) @(negedge clk);
    cpu_req_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule